// File: doc/BRIEF.md
# Sign-Test Branch and Link Unit

This unit resolves the "branch on the sign of a register" instruction group of a 32-bit load/store core. The group is selected by the primary opcode field (instruction bits 31..26) holding the value 1. Within the group, individual bits of the instruction choose the condition and whether a return address is produced. The unit does not use a full sub-opcode table.

Each cycle the unit takes four inputs: the instruction word, the value read from the source register, the address of the branch (the base for the target) and the address following the delay slot. It returns, one clock later, a redirect flag, the branch target, a write enable for the return-address register (register 31) and the value to write there. Fetch, delay-slot sequencing and the register file remain outside. The pipeline only consumes the registered decision.

In link mode the return address is always written, whether or not the branch is taken. A correct pipeline relies on this even for a branch that falls through.

Top module: `sign_branch_unit`

## Requirements
- R1: When instruction bit 16 is 1, the branch is taken (redirect = 1) exactly when the source value, read as a signed 32-bit number, is zero or positive.
- R2: When instruction bit 16 is 0, the branch is taken exactly when the source value, read as signed, is negative (bit 31 set).
- R3: When instruction bits 20..17 equal 4'b1000, link_we is 1 and link_data equals the delay-slot-follow address, whether or not the branch is taken.
- R4: When instruction bits 20..17 hold any other value (for example 4'b0000 or 4'b1001), link_we is 0 and link_data is 0.
- R5: For an enabled instruction, target equals the branch address plus the 16-bit immediate (bits 15..0), sign-extended and shifted left by two, modulo 2^32. This holds whether or not the branch is taken.
- R6: When in_valid is 0, or the opcode field (bits 31..26) is not 1, redirect, link_we, target and link_data are all 0.
- R7: Outputs are registered. They reflect the inputs sampled at the previous rising clock edge, with no further latency.
- R8: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Raw instruction word |
| src_val | input | 32 | Value of the source register |
| br_pc | input | 32 | Base address for the branch target |
| next_pc | input | 32 | Address after the delay slot, used as the return address |
| redirect | output | 1 | Branch taken; fetch goes to target after the delay slot |
| target | output | 32 | Computed branch target |
| link_we | output | 1 | Write enable for register 31 |
| link_data | output | 32 | Return address to write into register 31 |

## Verification
The bench stresses the sign boundary at the points where a wrong comparison shows. These are zero, minus one and the most negative value. A design that compared unsigned, or that treated zero as negative, would flip the redirect there.

It issues a linking branch whose condition fails and expects the link write anyway. A design that gated the link with the decision would drop the return address.

It sets bit 20 together with a nonzero low link field. This is meant to catch a decoder that looks only at bit 20.

It also checks negative offsets and targets that wrap past the top of the address space. It checks that a foreign opcode leaves every output at zero.

// File: rtl/sign_branch_unit.sv
module sign_branch_unit #(
  parameter int XW        = 32,
  parameter int GROUP_OPC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [XW-1:0] src_val,
  input  logic [XW-1:0] br_pc,
  input  logic [XW-1:0] next_pc,
  output logic          redirect,
  output logic [XW-1:0] target,
  output logic          link_we,
  output logic [XW-1:0] link_data
);

  localparam int OFFW = XW - 18;

  logic          en, want_ge, is_link, neg, take;
  logic [XW-1:0] offs, tgt;

  assign en      = in_valid && (instr[31:26] == 6'(GROUP_OPC));
  assign want_ge = instr[16];
  assign is_link = (instr[20:17] == 4'b1000);
  assign neg     = src_val[XW-1];
  assign take    = want_ge ? !neg : neg;
  assign offs    = {{OFFW{instr[15]}}, instr[15:0], 2'b00};
  assign tgt     = br_pc + offs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect  <= 1'b0;
      target    <= '0;
      link_we   <= 1'b0;
      link_data <= '0;
    end else begin
      redirect  <= en && take;
      target    <= en ? tgt : '0;
      link_we   <= en && is_link;
      link_data <= (en && is_link) ? next_pc : '0;
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_GE_SIGN: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (redirect && $past(instr[16])) |-> !$past(src_val[XW-1]));  // R1
  AST_LT_SIGN: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (redirect && !$past(instr[16])) |-> $past(src_val[XW-1]));  // R2
  AST_LINK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(in_valid && instr[31:26] == 6'(GROUP_OPC) && instr[20:17] == 4'b1000)
      |-> (link_we && link_data == $past(next_pc)));  // R3
  AST_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(instr[20:17] != 4'b1000) |-> !link_we);  // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(in_valid) |-> (!redirect && !link_we && target == '0));  // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(!rst_n) |-> (!redirect && !link_we));  // R8

endmodule

// File: tb/sim_sign_branch_unit.sv
module sim_sign_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, in_valid;
  logic [31:0] instr, src_val, br_pc, next_pc;
  logic        redirect, link_we;
  logic [31:0] target, link_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sign_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_val(src_val), .br_pc(br_pc), .next_pc(next_pc),
    .redirect(redirect), .target(target), .link_we(link_we), .link_data(link_data)
  );

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rtf,
                                     input logic [15:0] imm);
    return {opc, 5'd3, rtf, imm};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive one instruction, wait one edge, compare all outputs against spec.
  task automatic run(input string req, input logic v, input logic [31:0] ins,
                     input logic [31:0] sv, input logic [31:0] pc, input logic [31:0] npc,
                     input logic exp_red, input logic exp_lw);
    logic en;
    logic [31:0] exp_tgt;
    @(negedge clk);
    in_valid = v; instr = ins; src_val = sv; br_pc = pc; next_pc = npc;
    en = v && (ins[31:26] == 6'd1);
    exp_tgt = en ? pc + {{14{ins[15]}}, ins[15:0], 2'b00} : 32'd0;
    @(posedge clk); #1;
    chk(req, "redirect", {31'd0, redirect}, {31'd0, exp_red});
    chk(req, "link_we", {31'd0, link_we}, {31'd0, exp_lw});
    chk(req, "link_data", link_data, exp_lw ? npc : 32'd0);
    chk("R5", "target", target, exp_tgt);
  endtask

  task automatic t_reset;
    rst_n = 0; in_valid = 1; instr = mk(6'd1, 5'b10001, 16'h0004);
    src_val = 0; br_pc = 32'h100; next_pc = 32'h108;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "redirect", {31'd0, redirect}, 0);
    chk("R8", "link_we", {31'd0, link_we}, 0);
    chk("R8", "target", target, 0);
    @(negedge clk); rst_n = 1; in_valid = 0;
  endtask

  task automatic t_ge;
    run("R1", 1, mk(6'd1, 5'b00001, 16'h0010), 32'd0,        32'h1000, 32'h1008, 1, 0);
    run("R1", 1, mk(6'd1, 5'b00001, 16'h0010), 32'd5,        32'h1000, 32'h1008, 1, 0);
    run("R1", 1, mk(6'd1, 5'b00001, 16'h0010), 32'hffffffff, 32'h1000, 32'h1008, 0, 0);
    run("R1", 1, mk(6'd1, 5'b00001, 16'h0010), 32'h7fffffff, 32'h1000, 32'h1008, 1, 0);
  endtask

  task automatic t_lt;
    run("R2", 1, mk(6'd1, 5'b00000, 16'h0020), 32'hffffffff, 32'h2000, 32'h2008, 1, 0);
    run("R2", 1, mk(6'd1, 5'b00000, 16'h0020), 32'h80000000, 32'h2000, 32'h2008, 1, 0);
    run("R2", 1, mk(6'd1, 5'b00000, 16'h0020), 32'd0,        32'h2000, 32'h2008, 0, 0);
  endtask

  task automatic t_link;
    run("R3", 1, mk(6'd1, 5'b10000, 16'h0008), 32'd7,        32'h3000, 32'h3008, 0, 1);
    run("R3", 1, mk(6'd1, 5'b10000, 16'h0008), 32'hfffffff0, 32'h3000, 32'h3008, 1, 1);
    run("R3", 1, mk(6'd1, 5'b10001, 16'h0008), 32'hfffffff0, 32'h3100, 32'h3108, 0, 1);
    run("R3", 1, mk(6'd1, 5'b10001, 16'h0008), 32'd0,        32'h3100, 32'h3108, 1, 1);
  endtask

  task automatic t_nolink;
    run("R4", 1, mk(6'd1, 5'b10011, 16'h0001), 32'd1,        32'h4000, 32'h4008, 1, 0);
    run("R4", 1, mk(6'd1, 5'b11000, 16'h0001), 32'hffffffff, 32'h4000, 32'h4008, 1, 0);
    run("R4", 1, mk(6'd1, 5'b00010, 16'h0001), 32'hffffffff, 32'h4000, 32'h4008, 1, 0);
  endtask

  task automatic t_target;
    run("R5", 1, mk(6'd1, 5'b00001, 16'hfffe), 32'd1, 32'h5000, 32'h5008, 1, 0);
    run("R5", 1, mk(6'd1, 5'b00001, 16'h8000), 32'd1, 32'h00010000, 32'h8, 1, 0);
    run("R5", 1, mk(6'd1, 5'b00001, 16'h7fff), 32'd1, 32'hfffffff0, 32'h8, 1, 0);
    run("R5", 1, mk(6'd1, 5'b00000, 16'h0040), 32'd1, 32'h6000, 32'h6008, 0, 0);
  endtask

  task automatic t_disabled;
    run("R6", 1, mk(6'd0, 5'b10001, 16'h0004), 32'd0,        32'h7000, 32'h7008, 0, 0);
    run("R6", 1, mk(6'd3, 5'b10000, 16'h0004), 32'hffffffff, 32'h7000, 32'h7008, 0, 0);
    run("R6", 0, mk(6'd1, 5'b10001, 16'h0004), 32'd0,        32'h7000, 32'h7008, 0, 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_valid = 1; instr = mk(6'd1, 5'b10001, 16'h0002);
    src_val = 0; br_pc = 32'h8000; next_pc = 32'h8008;
    #1;
    chk("R7", "redirect before edge", {31'd0, redirect}, 0);
    @(posedge clk); #1;
    chk("R7", "redirect after edge", {31'd0, redirect}, 1);
    chk("R7", "link_data after edge", link_data, 32'h8008);
    @(negedge clk); in_valid = 0;
    @(posedge clk); #1;
    chk("R7", "redirect drops", {31'd0, redirect}, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_ge();
    t_lt();
    t_link();
    t_nolink();
    t_target();
    t_disabled();
    t_latency();
    finish_run();
  end
endmodule